// File: doc/BRIEF.md
# Flash Command Sequencer with Erase Suspend

This block models the command state machine of a parallel NOR flash and the embedded erase that it starts. The host issues bus write cycles (address, data word, write strobe). A six-write unlocked sequence starts either a whole-array erase or a single-sector erase. The erase runs on a small internal word array.

The embedded erase works in three passes over the target words, one word per clock. The first pass programs every target word to zero. The second pass checks that each word reads zero. The third pass sets every word to all ones. A sector erase can be suspended and later resumed, and it continues from the word where it halted. A whole-array erase cannot be suspended.

A read returns array data when the block is idle. When an erase is running, a read returns a status word. When an erase is suspended, a read of the suspended sector returns the status word. A separate unlock-bypass mode can be entered and left. In this model it only blocks other commands.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `busy`, `suspended` and `bypass_on` are 0, and the word at index i reads ((i*257) XOR 0x5A3C) truncated to 16 bits.
- R2: A command is recognized only when the whole data word equals its code. Unlock writes are 0x00AA at address 0x555, then 0x0055 at address 0x2AA. Set-up is 0x0080 at 0x555. A whole-array erase is the two unlock writes, set-up, the two unlock writes again, then 0x0010 at 0x555. While an erase runs, every read returns 0x0000.
- R3: The erase handles one word per clock in each of its three passes. `busy` falls exactly 3 × (target words) rising edges after the edge that sampled the sixth write. After that, reads return array data and every target word reads 0xFFFF.
- R4: A sector erase ends its sequence with 0x0030 written to any address inside the sector. The sector number is address bits [5:4], so each sector holds 16 words. Only that sector is erased.
- R5: A write that does not match the expected cycle sends the sequencer back to read mode. Later writes that would have completed the sequence start nothing.
- R6: During a whole-array erase every write is ignored, suspend included. `suspended` stays 0 and the erase duration is unchanged.
- R7: During a sector erase, every write other than suspend (0x00B0, any address) is ignored and does not change the erase duration.
- R8: A suspend is sampled on edge Es. The erase keeps working on edges Es+1 through Es+SUSP_DELAY. On edge Es+SUSP_DELAY+1, `suspended` rises and `busy` falls.
- R9: While suspended, reads inside the suspended sector return 0x0084: bit 7 is 1 when not actively erasing, and bit 2 is 1 when suspended. Reads elsewhere return array data.
- R10: While suspended, only 0x0030 (any address) is accepted, and it resumes the erase. After a resume on edge Er, `busy` falls on edge Er + 48 − (words already worked). That count is the edges from the start through Es, plus SUSP_DELAY.
- R11: Writing the two unlock cycles and then 0x0020 at 0x555 sets `bypass_on`. In bypass mode erase sequences are ignored. Only 0x0090 followed by 0x0000 (any address) clears `bypass_on`. A 0x0090 followed by any other word leaves the mode set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 11 | Word address for writes and reads |
| bus_wdata | input | 16 | Write data / command code |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| rd_data | output | 16 | Array data or status word (combinational from `bus_addr`) |
| busy | output | 1 | Erase actively running |
| suspended | output | 1 | Sector erase halted by suspend |
| bypass_on | output | 1 | Unlock-bypass mode active |

## Verification
A wrong erase cursor or pass sequencing shows up as a `busy` fall on the wrong edge, because the duration is exactly three edges per word. It also shows up as words that still hold seed data after the erase ends, and both are checked as soon as `busy` drops. A wrong suspend counter moves the `suspended` rise away from its exact edge. A lost cursor across a suspend moves the end edge after resume. A wrong sector mask shows up at once as status in place of data, or data in place of status, when the neighbouring sectors are read. Sequencer state that leaks shows up as erases that start, or fail to start, when the write sequence ends.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [10:0] UNLK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_UNLK_A  = 8'hAA;
    localparam logic [7:0] CODE_UNLK_B  = 8'h55;
    localparam logic [7:0] CODE_SETUP   = 8'h80;
    localparam logic [7:0] CODE_WHOLE   = 8'h10;
    localparam logic [7:0] CODE_SECTOR  = 8'h30;
    localparam logic [7:0] CODE_HALT    = 8'hB0;
    localparam logic [7:0] CODE_BYP_IN  = 8'h20;
    localparam logic [7:0] CODE_BYP_X1  = 8'h90;
    localparam logic [7:0] CODE_BYP_X2  = 8'h00;

    typedef enum logic [2:0] {
        SQ_READ, SQ_U1, SQ_U2, SQ_SETUP, SQ_U4, SQ_U5, SQ_BYP, SQ_BYP_X
    } seq_t;

    typedef enum logic [1:0] {EN_IDLE, EN_RUN, EN_SUSP} eng_t;

    typedef enum logic [1:0] {PH_PREP, PH_VFY, PH_ERASE} phase_t;

    typedef struct packed {
        logic whole;
        logic sector;
        logic halt;
        logic resume;
    } req_t;

    function automatic logic [31:0] seed_word(input int unsigned i);
        return (i * 32'h0000_0101) ^ 32'h0000_5A3C;
    endfunction

    function automatic logic [7:0] status_byte(input logic run, input logic held);
        logic [7:0] s;
        s    = 8'h00;
        s[7] = ~run;
        s[2] = held;
        return s;
    endfunction

endpackage

// File: rtl/fcs_decoder.sv
module fcs_decoder
    import flash_cmd_pkg::*;
#(
    parameter int BUS_AW = 11,
    parameter int DATA_W = 16,
    parameter int MEM_AW = 6,
    parameter int SECT_AW = 4,
    localparam int SIW = MEM_AW - SECT_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_run,
    input  logic              eng_held,
    output req_t              req,
    output logic [SIW-1:0]    req_sect,
    output logic              bypass_on
);

    seq_t state, nxt;

    logic at_a, at_b;
    assign at_a = (addr == BUS_AW'(UNLK_ADDR_A));
    assign at_b = (addr == BUS_AW'(UNLK_ADDR_B));

    function automatic logic is_code(input logic [DATA_W-1:0] d, input logic [7:0] c);
        return d == DATA_W'(c);
    endfunction

    assign req_sect  = addr[MEM_AW-1:SECT_AW];
    assign bypass_on = (state == SQ_BYP) || (state == SQ_BYP_X);

    always_comb begin
        nxt = state;
        req = '0;
        if (we) begin
            if (eng_run) begin
                req.halt = is_code(wdata, CODE_HALT);
            end else if (eng_held) begin
                req.resume = is_code(wdata, CODE_SECTOR);
            end else begin
                case (state)
                    SQ_READ:  if (at_a && is_code(wdata, CODE_UNLK_A)) nxt = SQ_U1;
                    SQ_U1:    nxt = (at_b && is_code(wdata, CODE_UNLK_B)) ? SQ_U2 : SQ_READ;
                    SQ_U2: begin
                        if (at_a && is_code(wdata, CODE_SETUP))       nxt = SQ_SETUP;
                        else if (at_a && is_code(wdata, CODE_BYP_IN)) nxt = SQ_BYP;
                        else                                          nxt = SQ_READ;
                    end
                    SQ_SETUP: nxt = (at_a && is_code(wdata, CODE_UNLK_A)) ? SQ_U4 : SQ_READ;
                    SQ_U4:    nxt = (at_b && is_code(wdata, CODE_UNLK_B)) ? SQ_U5 : SQ_READ;
                    SQ_U5: begin
                        nxt = SQ_READ;
                        if (at_a && is_code(wdata, CODE_WHOLE)) req.whole = 1'b1;
                        else if (is_code(wdata, CODE_SECTOR))  req.sector = 1'b1;
                    end
                    SQ_BYP:   if (is_code(wdata, CODE_BYP_X1)) nxt = SQ_BYP_X;
                    SQ_BYP_X: nxt = is_code(wdata, CODE_BYP_X2) ? SQ_READ : SQ_BYP;
                    default:  nxt = SQ_READ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_READ;
        else     state <= nxt;
    end

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int SECT_AW = 4,
    parameter int DATA_W = 16,
    parameter int SUSP_DELAY = 3,
    localparam int SIW = MEM_AW - SECT_AW,
    localparam int NSECT = 1 << SIW,
    localparam int CW = $clog2(SUSP_DELAY + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [SIW-1:0]    req_sect,
    input  logic [DATA_W-1:0] cur_data,
    output logic [MEM_AW-1:0] cur_idx,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              run,
    output logic              held,
    output logic              whole_mode,
    output logic [NSECT-1:0]  sel_mask
);

    eng_t              st;
    phase_t            ph;
    logic [MEM_AW-1:0] idx, first, last;
    logic              pend;
    logic [CW-1:0]     cnt;
    logic              work, finishing;

    assign work      = (st == EN_RUN) && !(pend && cnt == '0);
    assign finishing = (ph == PH_ERASE) && (idx == last);
    assign wr_en     = work && (ph != PH_VFY);
    assign wr_data   = (ph == PH_ERASE) ? '1 : '0;
    assign cur_idx   = idx;
    assign run       = (st == EN_RUN);
    assign held      = (st == EN_SUSP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= EN_IDLE;
            ph         <= PH_PREP;
            idx        <= '0;
            first      <= '0;
            last       <= '0;
            pend       <= 1'b0;
            cnt        <= '0;
            whole_mode <= 1'b0;
            sel_mask   <= '0;
        end else begin
            case (st)
                EN_IDLE: begin
                    pend <= 1'b0;
                    ph   <= PH_PREP;
                    if (req.whole) begin
                        st         <= EN_RUN;
                        whole_mode <= 1'b1;
                        sel_mask   <= '1;
                        first      <= '0;
                        last       <= '1;
                        idx        <= '0;
                    end else if (req.sector) begin
                        st         <= EN_RUN;
                        whole_mode <= 1'b0;
                        sel_mask   <= NSECT'(1) << req_sect;
                        first      <= {req_sect, {SECT_AW{1'b0}}};
                        last       <= {req_sect, {SECT_AW{1'b1}}};
                        idx        <= {req_sect, {SECT_AW{1'b0}}};
                    end
                end
                EN_RUN: begin
                    if (!work) begin
                        st   <= EN_SUSP;
                        pend <= 1'b0;
                    end else begin
                        case (ph)
                            PH_PREP: begin
                                if (idx == last) begin
                                    ph  <= PH_VFY;
                                    idx <= first;
                                end else idx <= idx + 1'b1;
                            end
                            PH_VFY: begin
                                if (cur_data != '0) ph <= PH_PREP;
                                else if (idx == last) begin
                                    ph  <= PH_ERASE;
                                    idx <= first;
                                end else idx <= idx + 1'b1;
                            end
                            PH_ERASE: begin
                                if (finishing) begin
                                    st         <= EN_IDLE;
                                    sel_mask   <= '0;
                                    whole_mode <= 1'b0;
                                end else idx <= idx + 1'b1;
                            end
                            default: ph <= PH_PREP;
                        endcase
                        if (pend) cnt <= cnt - 1'b1;
                        else if (req.halt && !whole_mode && !finishing) begin
                            pend <= 1'b1;
                            cnt  <= CW'(SUSP_DELAY);
                        end
                    end
                end
                EN_SUSP: if (req.resume) st <= EN_RUN;
                default: st <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MEM_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_word
);

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_idx];
    assign wr_word = mem[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(seed_word(i));
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int BUS_AW = 11,
    parameter int DATA_W = 16,
    parameter int MEM_AW = 6,
    parameter int SECT_AW = 4,
    parameter int SUSP_DELAY = 3,
    localparam int SIW = MEM_AW - SECT_AW,
    localparam int NSECT = 1 << SIW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              suspended,
    output logic              bypass_on
);

    req_t              req;
    logic [SIW-1:0]    req_sect;
    logic              eng_run, eng_held, eng_chip;
    logic [NSECT-1:0]  sel_mask;
    logic [MEM_AW-1:0] cur_idx;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data, cur_data, arr_rd;
    logic              show_stat;

    fcs_decoder #(
        .BUS_AW(BUS_AW), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW)
    ) u_dec (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .eng_run(eng_run), .eng_held(eng_held),
        .req(req), .req_sect(req_sect), .bypass_on(bypass_on)
    );

    fcs_engine #(
        .MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .DATA_W(DATA_W), .SUSP_DELAY(SUSP_DELAY)
    ) u_eng (
        .clk(clk), .rst(rst), .req(req), .req_sect(req_sect),
        .cur_data(cur_data), .cur_idx(cur_idx), .wr_en(wr_en), .wr_data(wr_data),
        .run(eng_run), .held(eng_held), .whole_mode(eng_chip), .sel_mask(sel_mask)
    );

    fcs_array #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(cur_idx), .wr_data(wr_data),
        .rd_idx(bus_addr[MEM_AW-1:0]), .rd_data(arr_rd), .wr_word(cur_data)
    );

    assign show_stat = eng_run || (eng_held && sel_mask[bus_addr[MEM_AW-1:SECT_AW]]);
    assign rd_data   = show_stat ? {{(DATA_W-8){1'b0}}, status_byte(eng_run, eng_held)}
                                 : arr_rd;
    assign busy      = eng_run;
    assign suspended = eng_held;

endmodule

// File: rtl/fcs_chk.sv
module fcs_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              suspended,
    input logic              bypass_on,
    input logic [DATA_W-1:0] rd_data,
    input logic              chip_mode
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !suspended && !bypass_on));

    a_r2_status_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd_data == '0));

    a_r6_whole_never_held: assert property (@(posedge clk) disable iff (rst)
        chip_mode |-> !suspended);

    a_r8_hold_follows_run: assert property (@(posedge clk) disable iff (rst)
        $rose(suspended) |-> $past(busy));

    a_r10_run_hold_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && suspended));

    a_r11_bypass_only_idle: assert property (@(posedge clk) disable iff (rst)
        bypass_on |-> (!busy && !suspended));

endmodule

bind flash_cmd_seq fcs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .suspended(suspended),
    .bypass_on(bypass_on), .rd_data(rd_data), .chip_mode(eng_chip)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;

    localparam int AW = 11;
    localparam int DW = 16;
    localparam int SD = 3;
    localparam int N  = 64;
    localparam int W  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          we = 1'b0;
    logic [DW-1:0] rdat;
    logic          busy, susp, byp;

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    int t_last = 0;
    bit ended = 0;
    logic [DW-1:0] model [N];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_seq #(.BUS_AW(AW), .DATA_W(DW), .MEM_AW(6), .SECT_AW(4), .SUSP_DELAY(SD)) u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(din), .bus_we(we),
        .rd_data(rdat), .busy(busy), .suspended(susp), .bypass_on(byp)
    );

    function automatic logic [DW-1:0] seed(input int i);
        logic [31:0] v;
        v = (i * 257) ^ 32'h5A3C;
        return v[DW-1:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; din = d; we = 1'b1;
        @(posedge clk); #1 t_last = cyc;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; #1 d = rdat;
    endtask

    task automatic wait_idle(output int t);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (!busy) break;
        end
        t = cyc;
    endtask

    task automatic seq6(input logic [AW-1:0] a6, input logic [DW-1:0] d6);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(a6, d6);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 busy", busy, 0); chk("R1 suspended", susp, 0); chk("R1 bypass", byp, 0);
        rd(11'd0, v);  chk("R1 word0", v, seed(0));
        rd(11'd37, v); chk("R1 word37", v, seed(37));
        rd(11'd63, v); chk("R1 word63", v, seed(63));
    endtask

    task automatic t_bypass();
        logic [DW-1:0] v;
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0020);
        chk("R11 enter", byp, 1);
        seq6(11'h555, 16'h0010);
        chk("R11 erase blocked", busy, 0);
        wr(11'h0, 16'h0090); wr(11'h0, 16'h0012);
        chk("R11 bad exit stays", byp, 1);
        wr(11'h0, 16'h0090); wr(11'h7, 16'h0000);
        chk("R11 exit", byp, 0);
        rd(11'd5, v); chk("R11 data intact", v, model[5]);
    endtask

    task automatic t_abort();
        logic [DW-1:0] v;
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0012); wr(11'h010, 16'h0030);
        chk("R5 bad fifth cycle", busy, 0);
        wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h0080);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0010);
        chk("R5 bad second cycle", busy, 0);
        chk("R5 not held", susp, 0);
        rd(11'h010, v); chk("R5 data intact", v, model[16]);
    endtask

    task automatic t_sector();
        logic [DW-1:0] v;
        int e0, t;
        seq6(11'h01A, 16'h0030);
        e0 = t_last;
        chk("R4 start", busy, 1);
        rd(11'h005, v); chk("R2 status on read", v, 16'h0000);
        wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); wr(11'h555, 16'h0010); wr(11'h025, 16'h0030);
        wait_idle(t);
        chk("R7 duration unchanged", t - e0, 3 * W);
        for (int i = 16; i < 32; i++) model[i] = 16'hFFFF;
        rd(11'h010, v); chk("R3 first word", v, 16'hFFFF);
        rd(11'h01F, v); chk("R3 last word", v, 16'hFFFF);
        rd(11'h00F, v); chk("R4 below sector", v, model[15]);
        rd(11'h020, v); chk("R4 above sector", v, model[32]);
        chk("R4 not held", susp, 0);
    endtask

    task automatic t_suspend();
        logic [DW-1:0] v;
        int e0, es, er, t, done;
        seq6(11'h02C, 16'h0030);
        e0 = t_last;
        repeat (5) @(negedge clk);
        wr(11'h7FF, 16'h00B0);
        es = t_last;
        chk("R8 not yet held", susp, 0);
        repeat (SD) @(negedge clk);
        chk("R8 held before deadline", susp, 0);
        chk("R8 still busy", busy, 1);
        @(negedge clk);
        chk("R8 held at deadline", susp, 1);
        chk("R8 busy low", busy, 0);
        done = (es - e0) + SD;
        rd(11'h025, v); chk("R9 status in sector", v, 16'h0084);
        rd(11'h005, v); chk("R9 data outside", v, model[5]);
        rd(11'h01F, v); chk("R9 erased neighbour", v, model[31]);
        wr(11'h555, 16'h00AA); wr(11'h000, 16'h00B0); wr(11'h555, 16'h0010);
        chk("R10 other writes ignored", susp, 1);
        wr(11'h000, 16'h0030);
        er = t_last;
        chk("R10 resumed", busy, 1);
        wait_idle(t);
        chk("R10 continues from cursor", t - er, 3 * W - done);
        for (int i = 32; i < 48; i++) model[i] = 16'hFFFF;
        rd(11'h020, v); chk("R10 sector start", v, 16'hFFFF);
        rd(11'h02F, v); chk("R10 sector end", v, 16'hFFFF);
        rd(11'h030, v); chk("R10 next sector", v, model[48]);
    endtask

    task automatic t_whole();
        logic [DW-1:0] v;
        int e0, t;
        seq6(11'h555, 16'h0010);
        e0 = t_last;
        wr(11'h000, 16'h00B0); wr(11'h555, 16'h00AA); wr(11'h100, 16'h00B0);
        repeat (SD + 2) @(negedge clk);
        chk("R6 suspend ignored", susp, 0);
        chk("R6 still busy", busy, 1);
        rd(11'h03F, v); chk("R2 status whole", v, 16'h0000);
        wait_idle(t);
        chk("R6 duration unchanged", t - e0, 3 * N);
        for (int i = 0; i < N; i++) begin
            rd(AW'(i), v);
            chk("R3 whole array erased", v, 16'hFFFF);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) model[i] = seed(i);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_bypass();
        t_abort();
        t_sector();
        t_suspend();
        t_whole();
        finish_run();
    end

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

endmodule